// File: doc/BRIEF.md
# Pointer Address Generation Unit

This unit sits beside the load/store path of a small 8-bit RISC core. It produces the 16-bit address for every data-memory access and every program-memory byte read. The register file supplies three 16-bit pointers, called X, Y and Z, and each one is built from a pair of byte registers. For each accepted request the unit forms the effective address from the chosen pointer, from a 6-bit unsigned displacement, or from a 16-bit constant. Where the mode changes the pointer, it also returns the new pointer value together with the register-file index of that pointer's pair.

When a request is accepted, the unit latches the address, destination register and write-back value, and then stays busy for the length of the access. A data access lasts two cycles and a program-memory read lasts three. A completion strobe marks the last cycle, and the pointer write-back enable is raised only in that cycle. While the unit is busy, and for any combination that is not allowed, a request is dropped and has no effect.

Top module: `ptr_agu`

## Requirements
- R1: While reset is active, and until the first accepted request, busy, done and ptr_we are low and mem_addr is 0.
- R2: Plain indirect mode (req_mode=0) addresses memory with the selected pointer (req_ptr 0=X, 1=Y, 2=Z) and does not write back.
- R3: Post-increment mode (req_mode=1) addresses with the pointer and writes back pointer+1 modulo 2^16, so 0xFFFF becomes 0x0000.
- R4: Pre-decrement mode (req_mode=2) addresses with pointer-1 modulo 2^16 and writes that same value back, so 0x0000 becomes 0xFFFF.
- R5: Displacement mode (req_mode=3) addresses with pointer+req_disp modulo 2^16 and leaves the pointer unchanged. It is accepted only for Y and Z.
- R6: Direct mode (req_mode=4) addresses with req_const, ignores req_ptr and does not write back.
- R7: An accepted data request holds busy high for exactly 2 cycles. mem_addr stays stable throughout, done is high only in the last cycle, and ptr_we is high only when done is high.
- R8: A program-memory request (req_prog=1) always uses Z, whatever req_ptr holds. It accepts mode 0 (plain) or mode 1 (post-increment Z), drives mem_prog high, and holds busy for exactly 3 cycles.
- R9: dst_reg equals req_dst, except for a program-memory request with req_dst_dflt=1, where dst_reg is register 0.
- R10: The unit ignores a request if it arrives while busy, if req_ptr=3 in a mode other than direct, if req_mode is 5 to 7, if a program read uses a mode above 1, or if X is used with displacement. In each case busy stays low and mem_addr keeps its previous value.
- R11: ptr_wsel gives the low register of the pair written back: 26 for X, 28 for Y, 30 for Z.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_prog | input | 1 | 1 = program-memory read, 0 = data access |
| req_ptr | input | 2 | Pointer select: 0 X, 1 Y, 2 Z |
| req_mode | input | 3 | Addressing mode code |
| req_disp | input | 6 | Unsigned displacement |
| req_const | input | 16 | Direct address constant |
| req_dst | input | 5 | Destination register for the access |
| req_dst_dflt | input | 1 | Program read goes to register 0 |
| ptr_x | input | 16 | Current X pointer |
| ptr_y | input | 16 | Current Y pointer |
| ptr_z | input | 16 | Current Z pointer |
| busy | output | 1 | Access in progress |
| done | output | 1 | Last cycle of the access |
| mem_addr | output | 16 | Effective address |
| mem_prog | output | 1 | Address targets program memory |
| dst_reg | output | 5 | Destination register of the access |
| ptr_we | output | 1 | Pointer write-back enable |
| ptr_wsel | output | 5 | Low register index of the pair written |
| ptr_wdata | output | 16 | New pointer value |

## Verification
Every output is registered on the edge that accepts a request. The bench drives each request at a falling edge and samples at the next falling edge, which is op cycle 1; it then expects busy on each falling edge through cycle 2 for a data access and cycle 3 for a program read. The bench checks done and ptr_we at exactly the final cycle, and expects busy to be low one falling edge after that. For a rejected request, the bench checks one falling edge after the strobe that busy is still low and mem_addr is unchanged. To test that requests are ignored while busy, it raises a second request during cycle 1 and then checks that the op length and address are unchanged.

// File: rtl/agu_pkg.sv
package agu_pkg;
  typedef enum logic [2:0] {
    AM_PLAIN   = 3'd0,
    AM_POSTINC = 3'd1,
    AM_PREDEC  = 3'd2,
    AM_DISP    = 3'd3,
    AM_DIRECT  = 3'd4
  } amode_e;

  typedef enum logic [1:0] {
    PS_X    = 2'd0,
    PS_Y    = 2'd1,
    PS_Z    = 2'd2,
    PS_NONE = 2'd3
  } psel_e;
endpackage

// File: rtl/agu_calc.sv
module agu_calc
  import agu_pkg::*;
#(
  parameter int AW        = 16,
  parameter int QW        = 6,
  parameter int RW        = 5,
  parameter int PAIR_BASE = 26
) (
  input  logic          req_prog,
  input  logic [1:0]    req_ptr,
  input  logic [2:0]    req_mode,
  input  logic [QW-1:0] req_disp,
  input  logic [AW-1:0] req_const,
  input  logic [RW-1:0] req_dst,
  input  logic          req_dst_dflt,
  input  logic [AW-1:0] ptr_x,
  input  logic [AW-1:0] ptr_y,
  input  logic [AW-1:0] ptr_z,
  output logic          ok,
  output logic [AW-1:0] ea,
  output logic          wb_en,
  output logic [AW-1:0] wb_val,
  output logic [RW-1:0] wb_reg,
  output logic [RW-1:0] dst
);
  localparam logic [AW-1:0] ONE = AW'(1);

  logic [1:0]    sel;
  logic [AW-1:0] base, inc, dec, off;

  always_comb begin
    sel = req_prog ? PS_Z : req_ptr;
    case (sel)
      PS_X:    base = ptr_x;
      PS_Y:    base = ptr_y;
      default: base = ptr_z;
    endcase
    inc = base + ONE;
    dec = base - ONE;
    off = base + {{(AW-QW){1'b0}}, req_disp};
  end

  always_comb begin
    ok     = 1'b0;
    ea     = base;
    wb_en  = 1'b0;
    wb_val = base;
    if (req_prog) begin
      ok     = (req_mode == AM_PLAIN) || (req_mode == AM_POSTINC);
      wb_en  = (req_mode == AM_POSTINC);
      wb_val = inc;
    end else begin
      case (req_mode)
        AM_PLAIN: ok = (sel != PS_NONE);
        AM_POSTINC: begin
          ok     = (sel != PS_NONE);
          wb_en  = 1'b1;
          wb_val = inc;
        end
        AM_PREDEC: begin
          ok     = (sel != PS_NONE);
          ea     = dec;
          wb_en  = 1'b1;
          wb_val = dec;
        end
        AM_DISP: begin
          ok = (sel == PS_Y) || (sel == PS_Z);
          ea = off;
        end
        AM_DIRECT: begin
          ok = 1'b1;
          ea = req_const;
        end
        default: ok = 1'b0;
      endcase
    end
    wb_reg = RW'(PAIR_BASE) + RW'({sel, 1'b0});
    dst    = (req_prog && req_dst_dflt) ? '0 : req_dst;
  end
endmodule

// File: rtl/agu_seq.sv
module agu_seq #(
  parameter int DATA_CYC = 2,
  parameter int PROG_CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic is_prog,
  output logic busy,
  output logic done
);
  localparam int MAXC = (PROG_CYC > DATA_CYC) ? PROG_CYC : DATA_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  logic          busy_q, busy_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (start) begin
      busy_d = 1'b1;
      cnt_d  = is_prog ? CW'(PROG_CYC - 1) : CW'(DATA_CYC - 1);
    end else if (busy_q) begin
      if (cnt_q == '0) busy_d = 1'b0;
      else             cnt_d  = cnt_q - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

  assign busy = busy_q;
  assign done = busy_q && (cnt_q == '0);

  // R7 / R8: an op never runs longer than the longest access
  p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (cnt_q < CW'(MAXC)));
  // R7: the completion cycle is followed by idle
  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy_q);
endmodule

// File: rtl/ptr_agu.sv
module ptr_agu
  import agu_pkg::*;
#(
  parameter int AW        = 16,
  parameter int QW        = 6,
  parameter int RW        = 5,
  parameter int PAIR_BASE = 26,
  parameter int DATA_CYC  = 2,
  parameter int PROG_CYC  = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_prog,
  input  logic [1:0]    req_ptr,
  input  logic [2:0]    req_mode,
  input  logic [QW-1:0] req_disp,
  input  logic [AW-1:0] req_const,
  input  logic [RW-1:0] req_dst,
  input  logic          req_dst_dflt,
  input  logic [AW-1:0] ptr_x,
  input  logic [AW-1:0] ptr_y,
  input  logic [AW-1:0] ptr_z,
  output logic          busy,
  output logic          done,
  output logic [AW-1:0] mem_addr,
  output logic          mem_prog,
  output logic [RW-1:0] dst_reg,
  output logic          ptr_we,
  output logic [RW-1:0] ptr_wsel,
  output logic [AW-1:0] ptr_wdata
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i_n = rst_sync[1];

  logic          c_ok, c_wbe;
  logic [AW-1:0] c_ea, c_wbv;
  logic [RW-1:0] c_wbr, c_dst;
  logic          start;

  agu_calc #(.AW(AW), .QW(QW), .RW(RW), .PAIR_BASE(PAIR_BASE)) u_calc (
    .req_prog     (req_prog),
    .req_ptr      (req_ptr),
    .req_mode     (req_mode),
    .req_disp     (req_disp),
    .req_const    (req_const),
    .req_dst      (req_dst),
    .req_dst_dflt (req_dst_dflt),
    .ptr_x        (ptr_x),
    .ptr_y        (ptr_y),
    .ptr_z        (ptr_z),
    .ok           (c_ok),
    .ea           (c_ea),
    .wb_en        (c_wbe),
    .wb_val       (c_wbv),
    .wb_reg       (c_wbr),
    .dst          (c_dst)
  );

  agu_seq #(.DATA_CYC(DATA_CYC), .PROG_CYC(PROG_CYC)) u_seq (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .start   (start),
    .is_prog (req_prog),
    .busy    (busy),
    .done    (done)
  );

  assign start = req_valid && c_ok && !busy;

  logic [AW-1:0] addr_q, wbv_q;
  logic [RW-1:0] dst_q, wbr_q;
  logic          prog_q, wbe_q;
  logic [2:0]    mode_q;

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      addr_q <= '0;
      wbv_q  <= '0;
      dst_q  <= '0;
      wbr_q  <= '0;
      prog_q <= 1'b0;
      wbe_q  <= 1'b0;
      mode_q <= '0;
    end else if (start) begin
      addr_q <= c_ea;
      wbv_q  <= c_wbv;
      dst_q  <= c_dst;
      wbr_q  <= c_wbr;
      prog_q <= req_prog;
      wbe_q  <= c_wbe;
      mode_q <= req_mode;
    end
  end

  assign mem_addr  = addr_q;
  assign mem_prog  = prog_q;
  assign dst_reg   = dst_q;
  assign ptr_we    = done && wbe_q;
  assign ptr_wsel  = wbr_q;
  assign ptr_wdata = wbv_q;

  // R7: address is held for the whole access
  p_addr_hold_r7: assert property (@(posedge clk) disable iff (!rst_i_n)
    (busy && $past(busy)) |-> $stable(addr_q));
  // R7: write-back only in the completion cycle
  p_we_in_done_r7: assert property (@(posedge clk) disable iff (!rst_i_n)
    ptr_we |-> done);
  // R3: post-increment writes back address plus one
  p_postinc_r3: assert property (@(posedge clk) disable iff (!rst_i_n)
    (ptr_we && mode_q == AM_POSTINC) |-> (wbv_q == addr_q + AW'(1)));
  // R4: pre-decrement writes back the address it used
  p_predec_r4: assert property (@(posedge clk) disable iff (!rst_i_n)
    (ptr_we && !prog_q && mode_q == AM_PREDEC) |-> (wbv_q == addr_q));
endmodule

// File: tb/ptr_agu_bench.sv
`timescale 1ns/1ps
module ptr_agu_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_prog = 1'b0, req_dst_dflt = 1'b0;
  logic [1:0]  req_ptr = '0;
  logic [2:0]  req_mode = '0;
  logic [5:0]  req_disp = '0;
  logic [15:0] req_const = '0, ptr_x = '0, ptr_y = '0, ptr_z = '0;
  logic [4:0]  req_dst = '0;
  logic        busy, done, mem_prog, ptr_we;
  logic [15:0] mem_addr, ptr_wdata;
  logic [4:0]  dst_reg, ptr_wsel;

  int total = 0, bad = 0;
  bit finished = 0;
  logic [15:0] last_addr = 16'h0000;

  always #2.5 clk = ~clk;

  ptr_agu u_ptr_agu (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_prog(req_prog),
    .req_ptr(req_ptr), .req_mode(req_mode), .req_disp(req_disp),
    .req_const(req_const), .req_dst(req_dst), .req_dst_dflt(req_dst_dflt),
    .ptr_x(ptr_x), .ptr_y(ptr_y), .ptr_z(ptr_z), .busy(busy), .done(done),
    .mem_addr(mem_addr), .mem_prog(mem_prog), .dst_reg(dst_reg),
    .ptr_we(ptr_we), .ptr_wsel(ptr_wsel), .ptr_wdata(ptr_wdata)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // reference model written from the requirements
  function automatic bit model(input bit prog, input logic [1:0] ptr,
      input logic [2:0] mode, input logic [5:0] q, input logic [15:0] c,
      input logic [4:0] d, input bit dflt,
      input logic [15:0] px, input logic [15:0] py, input logic [15:0] pz,
      output logic [15:0] ea, output bit wbe, output logic [15:0] wbv,
      output logic [4:0] wsel, output logic [4:0] dst, output int len);
    logic [1:0] s;
    logic [15:0] p;
    bit legal;
    s = prog ? 2'd2 : ptr;
    p = (s == 2'd0) ? px : (s == 2'd1) ? py : pz;
    wsel = (s == 2'd0) ? 5'd26 : (s == 2'd1) ? 5'd28 : 5'd30;
    dst = (prog && dflt) ? 5'd0 : d;
    len = prog ? 3 : 2;
    ea = p; wbe = 0; wbv = p; legal = 0;
    if (prog) begin
      legal = (mode <= 3'd1);
      wbe = (mode == 3'd1);
      wbv = p + 16'd1;
    end else begin
      case (mode)
        3'd0: legal = (s != 2'd3);
        3'd1: begin legal = (s != 2'd3); wbe = 1; wbv = p + 16'd1; end
        3'd2: begin legal = (s != 2'd3); ea = p - 16'd1; wbe = 1; wbv = ea; end
        3'd3: begin legal = (s == 2'd1 || s == 2'd2); ea = p + {10'd0, q}; end
        3'd4: begin legal = 1; ea = c; end
        default: legal = 0;
      endcase
    end
    return legal;
  endfunction

  function automatic string tag_of(input bit prog, input logic [2:0] mode);
    if (prog) return "R8";
    case (mode)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic run_op(input bit prog, input logic [1:0] ptr,
      input logic [2:0] mode, input logic [5:0] q, input logic [15:0] c,
      input logic [4:0] d, input bit dflt, input logic [15:0] px,
      input logic [15:0] py, input logic [15:0] pz, input bit inject);
    logic [15:0] ea, wbv;
    logic [4:0] wsel, dst;
    bit wbe, legal;
    int len;
    string t;
    legal = model(prog, ptr, mode, q, c, d, dflt, px, py, pz,
                  ea, wbe, wbv, wsel, dst, len);
    t = tag_of(prog, mode);
    @(negedge clk);
    req_prog = prog; req_ptr = ptr; req_mode = mode; req_disp = q;
    req_const = c; req_dst = d; req_dst_dflt = dflt;
    ptr_x = px; ptr_y = py; ptr_z = pz; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (!legal) begin
      chk("R10", "rejected busy", busy, 0);
      chk("R10", "rejected addr", mem_addr, last_addr);
      chk("R10", "rejected we", ptr_we, 0);
      return;
    end
    for (int k = 1; k <= len; k++) begin
      chk(prog ? "R8" : "R7", "busy", busy, 1);
      chk(t, "addr", mem_addr, ea);
      chk("R8", "mem_prog", mem_prog, prog);
      chk("R9", "dst", dst_reg, dst);
      chk("R7", "done", done, (k == len));
      chk(wbe ? t : "R7", "we", ptr_we, (k == len) && wbe);
      if (k == len && wbe) begin
        chk("R11", "wsel", ptr_wsel, wsel);
        chk(t, "wdata", ptr_wdata, wbv);
      end
      if (k == 1 && inject) begin
        req_prog = 0; req_mode = 3'd4; req_const = ~c; req_valid = 1'b1;
      end
      @(negedge clk);
      req_valid = 1'b0;
    end
    chk(prog ? "R8" : "R7", "busy end", busy, 0);
    if (inject) chk("R10", "addr after busy req", mem_addr, ea);
    last_addr = ea;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "busy", busy, 0);
    chk("R1", "done", done, 0);
    chk("R1", "we", ptr_we, 0);
    chk("R1", "addr", mem_addr, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", "busy after release", busy, 0);
    chk("R1", "addr after release", mem_addr, 0);

    // directed corners
    run_op(0, 2'd0, 3'd1, 6'd0, 16'h0, 5'd3, 0, 16'hFFFF, 16'h1, 16'h2, 0);  // R3 wrap
    run_op(0, 2'd1, 3'd2, 6'd0, 16'h0, 5'd4, 0, 16'h5, 16'h0000, 16'h2, 0);  // R4 wrap
    run_op(0, 2'd2, 3'd3, 6'd63, 16'h0, 5'd5, 0, 16'h5, 16'h6, 16'hFFF0, 0); // R5 wrap
    run_op(0, 2'd1, 3'd3, 6'd0, 16'h0, 5'd6, 0, 16'h5, 16'h1234, 16'h0, 0);  // R5 q=0
    run_op(0, 2'd0, 3'd3, 6'd9, 16'h0, 5'd6, 0, 16'h5, 16'h6, 16'h7, 0);     // R10 X disp
    run_op(0, 2'd3, 3'd0, 6'd0, 16'h0, 5'd6, 0, 16'h5, 16'h6, 16'h7, 0);     // R10 ptr 3
    run_op(0, 2'd0, 3'd6, 6'd0, 16'h0, 5'd6, 0, 16'h5, 16'h6, 16'h7, 0);     // R10 mode 6
    run_op(0, 2'd3, 3'd4, 6'd0, 16'hBEEF, 5'd7, 0, 16'h5, 16'h6, 16'h7, 1);  // R6 + R10 busy
    run_op(1, 2'd0, 3'd1, 6'd0, 16'h0, 5'd9, 1, 16'h5, 16'h6, 16'hFFFF, 0);  // R8 Z+ wrap, R9
    run_op(1, 2'd1, 3'd0, 6'd0, 16'h0, 5'd9, 0, 16'h5, 16'h6, 16'h4321, 1);  // R8 plain
    run_op(1, 2'd2, 3'd2, 6'd0, 16'h0, 5'd9, 0, 16'h5, 16'h6, 16'h7, 0);     // R10 prog mode 2
    run_op(0, 2'd2, 3'd0, 6'd0, 16'h0, 5'd1, 0, 16'h5, 16'h6, 16'hAAAA, 0);  // R2

    for (int i = 0; i < 400; i++) begin
      logic [15:0] px, py, pz;
      px = ($urandom % 8 == 0) ? 16'hFFFF : 16'($urandom);
      py = ($urandom % 8 == 0) ? 16'h0000 : 16'($urandom);
      pz = 16'($urandom);
      run_op(($urandom % 4) == 0, 2'($urandom), 3'($urandom % 6),
             6'($urandom), 16'($urandom), 5'($urandom), 1'($urandom),
             px, py, pz, ($urandom % 5) == 0);
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule